// File: doc/BRIEF.md
# I2C Target for a 16-Bit Port Expander Register File

This block is the serial front end of a 16-bit port expander. An I2C master on SCL/SDA selects one of eight 8-bit registers with a command byte and then writes or reads any number of data bytes. The registers form four pairs: input, output, polarity inversion and configuration. After each data byte the register pointer moves to the other register of the same pair, so a long transfer alternates between the two halves of a 16-bit port.

SCL and SDA are sampled by the system clock through two-flop synchronisers and edge detected. SDA is only ever pulled low, through an output enable. Sixteen parallel pins feed the input pair, with each bit passed through the matching polarity bit. The output and configuration pairs drive two 16-bit parallel outputs.

Top module: `pexp_i2c_target`

## Requirements
- R1: A START (SDA falling while SCL is high) arms the target. The first byte is a 7-bit address followed by a R/W bit. On a match with `DEV_ADDR` the target pulls SDA low in the ninth clock. On a mismatch it gives no ACK and ignores all bus traffic until the next START.
- R2: In a write transfer, the byte after the address is a command byte. Its low 3 bits set the register pointer and its upper bits are ignored. The codes are 0/1 input, 2/3 output, 4/5 polarity and 6/7 configuration, and the odd code is the high byte.
- R3: Every data byte written or read flips bit 0 of the pointer. Bits 2:1 stay fixed, so transfers alternate 3,2,3 or 2,3,2, with no limit on the byte count.
- R4: A data byte written to an output or configuration register reaches `out_port_o` or `cfg_port_o` right after the falling edge of its ACK clock, not before.
- R5: Data bytes written to registers 0 and 1 are acknowledged but change nothing.
- R6: After a command write, a repeated START and the address with R/W = 1, the target returns the selected register, then alternates within the pair for as long as the master acknowledges.
- R7: When the master does not acknowledge a read byte, the target releases SDA and drives nothing until the next START.
- R8: The input registers load `pins_i` XOR the polarity register at the falling edge of each ACK clock. A read byte from the input pair carries that freshly captured value.
- R9: After reset, the output registers are 0xFF, polarity is 0x00, configuration is 0xFF, the inputs are 0x00 and SDA is released.
- R10: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | When high, the data line is pulled low |
| pins_i | input | 16 | Parallel input pins |
| out_port_o | output | 16 | Output register pair, high byte from register 3 |
| cfg_port_o | output | 16 | Configuration register pair, high byte from register 7 |

## Verification
The assertions assume a well-behaved master. SDA changes only while SCL is low, except at START and STOP. A STOP or START never falls inside the target's own ACK or data-drive window. Each SCL phase lasts well beyond the synchroniser latency. The bench's bus tasks build every bit from quarter-period phases of twelve system clocks and move SDA only a full quarter after SCL falls. It changes the parallel pins only while no ACK clock is falling.

// File: rtl/pexp_pkg.sv
package pexp_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_PAIRS = 4;
    localparam int NUM_REGS  = 2 * NUM_PAIRS;
    localparam int PTR_W     = $clog2(NUM_REGS);
    localparam int PORT_W    = 2 * BYTE_W;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);
    localparam int ADDR_W    = 7;
    localparam int POL_BASE  = 4;

    typedef logic [PTR_W-1:0]  reg_ptr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_RX,
        BUS_RX_ACK,
        BUS_TX,
        BUS_TX_ACK
    } bus_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_DATA
    } rx_phase_e;

    typedef enum logic [1:0] {
        PAIR_IN  = 2'd0,
        PAIR_OUT = 2'd1,
        PAIR_POL = 2'd2,
        PAIR_CFG = 2'd3
    } pair_e;

    typedef struct packed {
        logic  cmd_vld;
        logic  wr_vld;
        logic  tx_adv;
        byte_t data;
    } bus_evt_t;

    localparam byte_t RST_IN  = 8'h00;
    localparam byte_t RST_OUT = 8'hFF;
    localparam byte_t RST_POL = 8'h00;
    localparam byte_t RST_CFG = 8'hFF;

    function automatic pair_e pair_of(reg_ptr_t p);
        return pair_e'(p[PTR_W-1:1]);
    endfunction

    function automatic reg_ptr_t pair_partner(reg_ptr_t p);
        return {p[PTR_W-1:1], ~p[0]};
    endfunction

    function automatic byte_t reset_value(reg_ptr_t p);
        case (pair_of(p))
            PAIR_OUT: return RST_OUT;
            PAIR_POL: return RST_POL;
            PAIR_CFG: return RST_CFG;
            default:  return RST_IN;
        endcase
    endfunction

endpackage

// File: rtl/pexp_line_sync.sv
module pexp_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic q,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sr_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '1;
            prev_q <= 1'b1;
        end else begin
            sr_q   <= {sr_q[STAGES-2:0], din};
            prev_q <= sr_q[STAGES-1];
        end
    end

    assign q    = sr_q[STAGES-1];
    assign rise = q & ~prev_q;
    assign fall = ~q & prev_q;

endmodule

// File: rtl/pexp_bus_engine.sv
module pexp_bus_engine
    import pexp_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h20
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl,
    input  logic     scl_rise,
    input  logic     scl_fall,
    input  logic     sda,
    input  logic     sda_rise,
    input  logic     sda_fall,
    input  byte_t    tx_byte,
    output logic     sda_oe,
    output logic     ack_fall,
    output bus_evt_t evt
);
    bus_state_e           state_q;
    rx_phase_e            phase_q;
    logic [BIT_CNT_W-1:0] bitcnt_q;
    byte_t                sh_q;
    logic                 rw_q;
    logic                 mack_q;
    logic                 oe_q;
    bus_evt_t             evt_q;

    logic start_det, stop_det, byte_in_done, addr_hit;
    assign start_det    = scl & sda_fall;
    assign stop_det     = scl & sda_rise;
    assign byte_in_done = scl_fall && (bitcnt_q == BIT_CNT_W'(BYTE_W));
    assign addr_hit     = (sh_q[BYTE_W-1:1] == DEV_ADDR);
    assign ack_fall     = scl_fall && (state_q == BUS_RX_ACK || state_q == BUS_TX_ACK);

    always_ff @(posedge clk) begin
        evt_q <= '0;
        if (rst) begin
            state_q  <= BUS_IDLE;
            phase_q  <= PH_ADDR;
            bitcnt_q <= '0;
            sh_q     <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            oe_q     <= 1'b0;
        end else if (start_det) begin
            state_q  <= BUS_RX;
            phase_q  <= PH_ADDR;
            bitcnt_q <= '0;
            oe_q     <= 1'b0;
        end else if (stop_det) begin
            state_q <= BUS_IDLE;
            oe_q    <= 1'b0;
        end else begin
            case (state_q)
                BUS_RX: begin
                    if (scl_rise) begin
                        sh_q     <= {sh_q[BYTE_W-2:0], sda};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end else if (byte_in_done) begin
                        bitcnt_q <= '0;
                        if (phase_q != PH_ADDR || addr_hit) begin
                            oe_q    <= 1'b1;
                            state_q <= BUS_RX_ACK;
                            if (phase_q == PH_ADDR) rw_q <= sh_q[0];
                        end else begin
                            state_q <= BUS_IDLE;
                        end
                    end
                end
                BUS_RX_ACK: begin
                    if (scl_fall) begin
                        oe_q       <= 1'b0;
                        evt_q.data <= sh_q;
                        case (phase_q)
                            PH_ADDR: begin
                                if (rw_q) begin
                                    state_q <= BUS_TX;
                                    sh_q    <= tx_byte;
                                    oe_q    <= ~tx_byte[BYTE_W-1];
                                end else begin
                                    state_q <= BUS_RX;
                                    phase_q <= PH_CMD;
                                end
                            end
                            PH_CMD: begin
                                evt_q.cmd_vld <= 1'b1;
                                phase_q       <= PH_DATA;
                                state_q       <= BUS_RX;
                            end
                            default: begin
                                evt_q.wr_vld <= 1'b1;
                                state_q      <= BUS_RX;
                            end
                        endcase
                    end
                end
                BUS_TX: begin
                    if (scl_rise) begin
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end else if (byte_in_done) begin
                        bitcnt_q     <= '0;
                        oe_q         <= 1'b0;
                        state_q      <= BUS_TX_ACK;
                        evt_q.tx_adv <= 1'b1;
                    end else if (scl_fall) begin
                        sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
                        oe_q <= ~sh_q[BYTE_W-2];
                    end
                end
                BUS_TX_ACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            state_q <= BUS_TX;
                            sh_q    <= tx_byte;
                            oe_q    <= ~tx_byte[BYTE_W-1];
                        end else begin
                            state_q <= BUS_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe = oe_q;
    assign evt    = evt_q;

    // Address mismatch leaves the line released (R1)
    assert_no_ack_on_miss_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == BUS_RX && phase_q == PH_ADDR && byte_in_done && !addr_hit
         && !start_det && !stop_det) |=> (!oe_q && state_q == BUS_IDLE));

    // Drive changes only while the clock line is low (R10)
    assert_oe_moves_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        (oe_q != $past(oe_q)) |-> !$past(scl));

    // A master NACK ends the read and frees SDA (R7)
    assert_release_on_nack_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == BUS_TX_ACK && scl_fall && !mack_q && !start_det && !stop_det)
        |=> (state_q == BUS_IDLE && !oe_q));

    // Idle target never pulls the line (R7)
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == BUS_IDLE) |-> !oe_q);

endmodule

// File: rtl/pexp_regfile.sv
module pexp_regfile
    import pexp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic              cap,
    input  logic [PORT_W-1:0] pins,
    output byte_t             rd_byte,
    output logic [PORT_W-1:0] out_port,
    output logic [PORT_W-1:0] cfg_port
);
    byte_t    regs    [NUM_REGS];
    byte_t    live_in [2];
    reg_ptr_t ptr_q;

    for (genvar k = 0; k < 2; k++) begin : g_live
        assign live_in[k] = pins[k*BYTE_W +: BYTE_W] ^ regs[POL_BASE + k];
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        byte_t r_q;
        if (pair_of(reg_ptr_t'(i)) == PAIR_IN) begin : g_in
            always_ff @(posedge clk) begin
                if (rst)      r_q <= RST_IN;
                else if (cap) r_q <= live_in[i % 2];
            end
        end else begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)
                    r_q <= reset_value(reg_ptr_t'(i));
                else if (evt.wr_vld && ptr_q == reg_ptr_t'(i))
                    r_q <= evt.data;
            end
        end
        assign regs[i] = r_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (evt.cmd_vld)
            ptr_q <= evt.data[PTR_W-1:0];
        else if (evt.wr_vld || evt.tx_adv)
            ptr_q <= pair_partner(ptr_q);
    end

    always_comb begin
        if (pair_of(ptr_q) == PAIR_IN && cap)
            rd_byte = live_in[ptr_q[0]];
        else
            rd_byte = regs[ptr_q];
    end

    assign out_port = {regs[3], regs[2]};
    assign cfg_port = {regs[7], regs[6]};

    // Command byte loads the pointer from its low bits (R2)
    assert_cmd_loads_ptr_R2: assert property (@(posedge clk) disable iff (rst)
        evt.cmd_vld |=> (ptr_q == $past(evt.data[PTR_W-1:0])));

    // Pointer advance stays inside the selected pair (R3)
    assert_stay_in_pair_R3: assert property (@(posedge clk) disable iff (rst)
        ((evt.wr_vld || evt.tx_adv) && !evt.cmd_vld)
        |=> ($stable(ptr_q[PTR_W-1:1]) && ptr_q[0] != $past(ptr_q[0])));

    // Written output byte appears on the port (R4)
    assert_out_written_R4: assert property (@(posedge clk) disable iff (rst)
        (evt.wr_vld && pair_of(ptr_q) == PAIR_OUT)
        |=> (($past(ptr_q[0]) ? out_port[15:8] : out_port[7:0]) == $past(evt.data)));

    // Writes aimed at the input pair touch no driven port (R5)
    assert_input_write_inert_R5: assert property (@(posedge clk) disable iff (rst)
        (evt.wr_vld && pair_of(ptr_q) == PAIR_IN)
        |=> ($stable(out_port) && $stable(cfg_port)));

endmodule

// File: rtl/pexp_i2c_target.sv
module pexp_i2c_target
    import pexp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h20,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic [15:0] pins_i,
    output logic [15:0] out_port_o,
    output logic [15:0] cfg_port_o
);
    localparam int NUM_LINES = 2;
    localparam int LINE_SCL  = 0;
    localparam int LINE_SDA  = 1;

    logic [NUM_LINES-1:0] line_raw, line_q, line_rise, line_fall;
    assign line_raw = {sda_i, scl_i};

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_sync
        pexp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (line_raw[l]),
            .q    (line_q[l]),
            .rise (line_rise[l]),
            .fall (line_fall[l])
        );
    end

    bus_evt_t evt;
    logic     ack_fall;
    byte_t    rd_byte;

    pexp_bus_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .scl      (line_q[LINE_SCL]),
        .scl_rise (line_rise[LINE_SCL]),
        .scl_fall (line_fall[LINE_SCL]),
        .sda      (line_q[LINE_SDA]),
        .sda_rise (line_rise[LINE_SDA]),
        .sda_fall (line_fall[LINE_SDA]),
        .tx_byte  (rd_byte),
        .sda_oe   (sda_oe_o),
        .ack_fall (ack_fall),
        .evt      (evt)
    );

    pexp_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .cap      (ack_fall),
        .pins     (pins_i),
        .rd_byte  (rd_byte),
        .out_port (out_port_o),
        .cfg_port (cfg_port_o)
    );

endmodule

// File: tb/tb_pexp_i2c_target.sv
module tb_pexp_i2c_target;

    localparam int Q        = 12;
    localparam int WDOG_CYC = 190000;
    localparam logic [7:0] AW = 8'h40;
    localparam logic [7:0] AR = 8'h41;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        m_sda_low = 1'b0;
    logic        sda_oe;
    logic [15:0] pins = 16'h0000;
    logic [15:0] out_port, cfg_port;
    wire         sda_bus = !(m_sda_low || sda_oe);

    always #10 clk = ~clk;

    pexp_i2c_target dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .pins_i     (pins),
        .out_port_o (out_port),
        .cfg_port_o (cfg_port)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;
    exp_t       exp_q[$];
    event       rd_ev;
    logic [7:0] rd_val;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic expect_rd(logic [7:0] v, string req);
        exp_t e;
        e.val = v;
        e.req = req;
        exp_q.push_back(e);
    endtask

    // Scoreboard monitor: pops one expected item per byte read
    initial begin
        forever begin
            @(rd_ev);
            if (exp_q.size() == 0) begin
                check("R6 unexpected read", {24'h0, rd_val}, 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, {24'h0, rd_val}, {24'h0, e.val});
            end
        end
    end

    task automatic qd;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda_low = 1'b0; qd;
        scl_m = 1'b1;     qd;
        m_sda_low = 1'b1; qd;
        scl_m = 1'b0;     qd;
    endtask

    task automatic bus_stop;
        m_sda_low = 1'b1; qd;
        scl_m = 1'b1;     qd;
        m_sda_low = 1'b0; qd;
    endtask

    task automatic send_bit(logic b);
        m_sda_low = !b; qd;
        scl_m = 1'b1;   qd; qd;
        scl_m = 1'b0;   qd;
    endtask

    task automatic recv_bit(output logic b);
        m_sda_low = 1'b0; qd;
        scl_m = 1'b1;     qd;
        b = sda_bus;      qd;
        scl_m = 1'b0;     qd;
    endtask

    task automatic send_bits(logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic wr_byte(logic [7:0] v, output logic acked);
        logic b;
        send_bits(v);
        recv_bit(b);
        acked = !b;
    endtask

    task automatic rd_byte(logic master_ack);
        logic [7:0] v;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(!master_ack);
        m_sda_low = 1'b0;
        rd_val = v;
        ->rd_ev;
    endtask

    task automatic wr_ack(logic [7:0] v, string req);
        logic a;
        wr_byte(v, a);
        check(req, {31'h0, a}, 32'h1);
    endtask

    task automatic set_ptr_read(logic [7:0] cmd);
        bus_start;
        wr_ack(AW, "R1 address ack");
        wr_ack(cmd, "R2 command ack");
        bus_start;
        wr_ack(AR, "R6 read address ack");
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic a, b;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R9: reset state
        check("R9 out reset", {16'h0, out_port}, 32'hFFFF);
        check("R9 cfg reset", {16'h0, cfg_port}, 32'hFFFF);
        check("R9 sda released", {31'h0, sda_oe}, 32'h0);

        // R3/R4: write 2,3,2 with commit timing on the first byte
        bus_start;
        wr_ack(AW, "R1 address ack");
        wr_ack(8'h02, "R2 command ack");
        send_bits(8'h12);
        check("R4 before ack fall", {16'h0, out_port}, 32'hFFFF);
        recv_bit(b);
        check("R4 data ack", {31'h0, !b}, 32'h1);
        check("R4 after ack fall", {16'h0, out_port}, 32'hFF12);
        wr_ack(8'h34, "R3 second byte ack");
        wr_ack(8'h56, "R3 third byte ack");
        bus_stop;
        check("R3 toggle 2-3-2", {16'h0, out_port}, 32'h3456);

        // R3: start on odd register
        bus_start;
        wr_ack(AW, "R1 address ack");
        wr_ack(8'h03, "R2 command ack");
        wr_ack(8'hA5, "R3 ack");
        wr_ack(8'h5A, "R3 ack");
        bus_stop;
        check("R3 toggle 3-2", {16'h0, out_port}, 32'hA55A);

        // R2: upper command bits ignored (0x0E selects register 6)
        bus_start;
        wr_ack(AW, "R1 address ack");
        wr_ack(8'h0E, "R2 command ack");
        wr_ack(8'h0F, "R2 data ack");
        bus_stop;
        check("R2 low bits select cfg0", {16'h0, cfg_port}, 32'hFF0F);

        // R1: wrong address gets no ACK and is ignored
        bus_start;
        wr_byte(8'h42, a);
        check("R1 no ack on miss", {31'h0, a}, 32'h0);
        wr_byte(8'h02, a);
        check("R1 silent after miss", {31'h0, a}, 32'h0);
        wr_byte(8'h00, a);
        bus_stop;
        check("R1 miss no effect", {16'h0, out_port}, 32'hA55A);

        // R5: writes to the input pair are acknowledged but inert
        bus_start;
        wr_ack(AW, "R1 address ack");
        wr_ack(8'h00, "R2 command ack");
        wr_ack(8'h77, "R5 input write ack");
        wr_ack(8'h88, "R5 input write ack");
        bus_stop;
        check("R5 out untouched", {16'h0, out_port}, 32'hA55A);
        check("R5 cfg untouched", {16'h0, cfg_port}, 32'hFF0F);

        // Polarity pair: reg4=F0, reg5=0F
        bus_start;
        wr_ack(AW, "R1 address ack");
        wr_ack(8'h04, "R2 command ack");
        wr_ack(8'hF0, "R3 ack");
        wr_ack(8'h0F, "R3 ack");
        bus_stop;

        // R8/R5/R6: input capture at each ACK fall, XOR polarity
        pins = 16'h1234;
        set_ptr_read(8'h00);
        pins = 16'hABCD;
        expect_rd(8'h34 ^ 8'hF0, "R8 input0 captured at address ack");
        expect_rd(8'hAB ^ 8'h0F, "R8 input1 recaptured");
        expect_rd(8'hCD ^ 8'hF0, "R5 input0 shows pins not written data");
        rd_byte(1'b1);
        rd_byte(1'b1);
        rd_byte(1'b0);

        // R7: after NACK the target drives nothing
        check("R7 released after nack", {31'h0, sda_oe}, 32'h0);
        recv_bit(b);
        check("R7 idle bit 1", {31'h0, b}, 32'h1);
        recv_bit(b);
        check("R7 idle bit 2", {31'h0, b}, 32'h1);
        bus_stop;

        // R6: output pair from register 3
        set_ptr_read(8'h03);
        expect_rd(8'hA5, "R6 out1");
        expect_rd(8'h5A, "R6 out0");
        expect_rd(8'hA5, "R6 out1 again");
        rd_byte(1'b1);
        rd_byte(1'b1);
        rd_byte(1'b0);
        bus_stop;

        // R6: configuration and polarity reads
        set_ptr_read(8'h07);
        expect_rd(8'hFF, "R6 cfg1");
        expect_rd(8'h0F, "R6 cfg0");
        rd_byte(1'b1);
        rd_byte(1'b0);
        bus_stop;

        set_ptr_read(8'h04);
        expect_rd(8'hF0, "R6 pol0");
        expect_rd(8'h0F, "R6 pol1");
        rd_byte(1'b1);
        rd_byte(1'b0);
        bus_stop;

        // R10: line released at the end
        qd;
        check("R10 released at end", {31'h0, sda_oe}, 32'h0);
        check("R6 scoreboard drained", exp_q.size(), 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule